// File: doc/BRIEF.md
# Two-Group Virtual Channel Transmit Arbiter

This block picks which virtual channel may send its next packet on a shared transmit path. Each of the `NUM_CH` channels raises a request bit. The arbiter answers with a registered one-hot grant. The grant stays in place until a `done` pulse releases it, and each grant covers one packet.

The channels form two groups. The lowest `LOW_CNT` channels, 0 to `LOW_CNT-1`, make up the low group. The remaining channels, `LOW_CNT` to `NUM_CH-1`, make up the high group. A request in the high group always beats every request in the low group. Inside the high group, the highest-numbered requesting channel wins. Inside the low group, a fixed round-robin order applies. A pointer marks the channel that is searched first, and the search runs upward from it and wraps.

With `LOW_CNT = 0` the block is a plain strict-priority arbiter. With `LOW_CNT = NUM_CH` it is a plain round-robin arbiter. Packet building, credit checks and framing are handled elsewhere.

Top module: `vc_tx_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant to zero and sets the round-robin pointer to channel 0. The first low-group arbitration after reset therefore searches upward from channel 0.
- R2: The grant is at most one-hot. A grant issued at an arbitration edge goes only to a channel whose request bit was high in the cycle before that edge.
- R3: Arbitration takes place at a clock edge only when the grant is zero or `done` is high. Otherwise the grant holds, whatever the requests do.
- R4: When any high-group channel is requesting at an arbitration edge, no low-group channel is granted.
- R5: Among requesting high-group channels, the highest-numbered channel is granted.
- R6: When only low-group channels request, the grant goes to the first requesting channel found by searching from the pointer upward, wrapping from `LOW_CNT-1` to 0.
- R7: When a low-group grant is issued, the pointer moves to the channel after the granted one, wrapping to 0. The pointer changes at no other time.
- R8: An arbitration edge with no requests produces an all-zero grant and leaves the pointer unchanged.
- R9: With `LOW_CNT = 0` the arbiter behaves as pure strict priority over all channels. With `LOW_CNT = NUM_CH` it behaves as pure round robin over all channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_CH | Request bit per channel; bit i is channel i |
| done | input | 1 | Releases the current grant and allows re-arbitration at this edge |
| grant | output | NUM_CH | Registered one-hot grant; bit i is channel i |

## Verification
The pointer cannot be seen at the ports. Its effect shows only in which low-group channel wins the next round where no high-group channel requests. The trickiest cases are therefore a pointer that must hold through idle rounds, and a pointer that must hold through rounds the high group wins. To reach them, the stimulus places idle rounds and high-group rounds between low-only rounds. Sparse low request patterns then reveal where the search starts. Long random runs with `done` asserted only now and then also cover grants that are held while the requests change underneath them.

// File: rtl/vca_pkg.sv
package vca_pkg;
  // index width for a vector of n entries, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vca_prio_pick.sv
// Strict priority: the highest-numbered requester wins.
module vca_prio_pick #(
  parameter int HW = 4
) (
  input  logic [HW-1:0] req,
  output logic [HW-1:0] gnt,
  output logic          hit
);
  always_comb begin
    gnt = '0;
    hit = 1'b0;
    for (int i = 0; i < HW; i++) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        hit    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vca_rr_pick.sv
// Round robin: search upward from ptr, wrapping; the nearest requester wins.
module vca_rr_pick #(
  parameter int LW = 4,
  parameter int PW = vca_pkg::idx_w(LW)
) (
  input  logic [LW-1:0] req,
  input  logic [PW-1:0] ptr,
  output logic [LW-1:0] gnt,
  output logic [PW-1:0] nxt_ptr,
  output logic          hit
);
  always_comb begin
    gnt     = '0;
    hit     = 1'b0;
    nxt_ptr = ptr;
    // scan from the farthest offset down so the nearest candidate is kept
    for (int k = LW - 1; k >= 0; k--) begin
      int c;
      c = (int'(ptr) + k) % LW;
      if (req[c]) begin
        gnt     = '0;
        gnt[c]  = 1'b1;
        hit     = 1'b1;
        nxt_ptr = (c == LW - 1) ? '0 : PW'(c + 1);
      end
    end
  end
endmodule

// File: rtl/vc_tx_arbiter.sv
module vc_tx_arbiter #(
  parameter int NUM_CH  = 8,
  parameter int LOW_CNT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  input  logic              done,
  output logic [NUM_CH-1:0] grant
);
  localparam int HI_CNT = NUM_CH - LOW_CNT;
  localparam int LW     = (LOW_CNT > 0) ? LOW_CNT : 1;
  localparam int HW     = (HI_CNT > 0) ? HI_CNT : 1;
  localparam int PW     = vca_pkg::idx_w(LW);

  logic [LW-1:0]     lo_gnt;
  logic [HW-1:0]     hi_gnt;
  logic              lo_hit, hi_hit;
  logic [PW-1:0]     ptr_q, ptr_nxt;
  logic [NUM_CH-1:0] pick;
  logic              arb_en;

  generate
    if (LOW_CNT > 0) begin : g_lo
      vca_rr_pick #(.LW(LW), .PW(PW)) u_rr (
        .req(req[LW-1:0]), .ptr(ptr_q), .gnt(lo_gnt),
        .nxt_ptr(ptr_nxt), .hit(lo_hit)
      );
    end else begin : g_no_lo
      assign lo_gnt  = '0;
      assign lo_hit  = 1'b0;
      assign ptr_nxt = '0;
    end

    if (HI_CNT > 0) begin : g_hi
      vca_prio_pick #(.HW(HW)) u_hi (
        .req(req[NUM_CH-1:LOW_CNT]), .gnt(hi_gnt), .hit(hi_hit)
      );
    end else begin : g_no_hi
      assign hi_gnt = '0;
      assign hi_hit = 1'b0;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_merge
      if (i < LOW_CNT) begin : g_l
        assign pick[i] = lo_gnt[i] & ~hi_hit;
      end else begin : g_h
        assign pick[i] = hi_gnt[i-LOW_CNT];
      end
    end
  endgenerate

  assign arb_en = (grant == '0) || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= '0;
      ptr_q <= '0;
    end else if (arb_en) begin
      grant <= pick;
      if (lo_hit && !hi_hit) ptr_q <= ptr_nxt;
    end
  end

  // R2: never more than one channel granted
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R2: a freshly issued grant lands on a channel that was requesting
  p_req_r2: assert property (@(posedge clk) disable iff (rst)
    arb_en |=> ((grant & $past(req)) == grant));
  // R3: without release the grant holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !arb_en |=> $stable(grant));
  // R7: pointer only moves at an arbitration edge
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !arb_en |=> $stable(ptr_q));
  // R8: idle arbitration clears grant and keeps pointer
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (arb_en && req == '0) |=> (grant == '0 && $stable(ptr_q)));

  generate
    if (LOW_CNT > 0 && HI_CNT > 0) begin : g_chk_mix
      // R4: a high-group request locks out the low group
      p_hi_first_r4: assert property (@(posedge clk) disable iff (rst)
        (arb_en && |req[NUM_CH-1:LOW_CNT]) |=> (grant[LOW_CNT-1:0] == '0));
      // R7: pointer holds when the high group wins
      p_ptr_hi_r7: assert property (@(posedge clk) disable iff (rst)
        (arb_en && |req[NUM_CH-1:LOW_CNT]) |=> $stable(ptr_q));
    end
  endgenerate
endmodule

// File: tb/sim_vc_tx_arbiter.sv
`timescale 1ns/1ps
module sim_vc_tx_arbiter;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req;
  logic       done;
  logic [7:0] g0;
  logic [3:0] g1, g2;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // model state per instance: granted channel (-1 none) and pointer
  int mg [3];
  int mp [3];
  int mn [3] = '{8, 4, 4};
  int ml [3] = '{3, 0, 4};

  always #5 clk = ~clk;

  vc_tx_arbiter #(.NUM_CH(8), .LOW_CNT(3)) u0 (
    .clk(clk), .rst(rst), .req(req), .done(done), .grant(g0));
  vc_tx_arbiter #(.NUM_CH(4), .LOW_CNT(0)) u1 (
    .clk(clk), .rst(rst), .req(req[3:0]), .done(done), .grant(g1));
  vc_tx_arbiter #(.NUM_CH(4), .LOW_CNT(4)) u2 (
    .clk(clk), .rst(rst), .req(req[3:0]), .done(done), .grant(g2));

  task automatic model_step(int k);
    int n, lc, w;
    n = mn[k]; lc = ml[k];
    if (rst) begin
      mg[k] = -1; mp[k] = 0;
    end else if (mg[k] < 0 || done) begin
      w = -1;
      for (int c = n - 1; c >= lc; c--)
        if (w < 0 && req[c]) w = c;
      if (w < 0) begin
        for (int j = 0; j < lc; j++) begin
          int c;
          c = (mp[k] + j) % lc;
          if (w < 0 && req[c]) begin
            w = c;
            mp[k] = (c + 1) % lc;
          end
        end
      end
      mg[k] = w;
    end
  endtask

  function automatic logic [7:0] ev(int k);
    return (mg[k] < 0) ? 8'h00 : (8'h01 << mg[k]);
  endfunction

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grant actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    for (int k = 0; k < 3; k++) model_step(k);
    @(negedge clk);
    cmp(tag, g0, ev(0));
    cmp("R9", {4'h0, g1}, ev(1));
    cmp("R9", {4'h0, g2}, ev(2));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req = '0; done = 1'b0;
    for (int k = 0; k < 3; k++) begin mg[k] = -1; mp[k] = 0; end
    cyc("R1"); cyc("R1");
    rst = 1'b0;
    cmp("R1", g0, 8'h00);
    // R6: all low channels asking, pointer walks 0,1,2,0
    req = 8'b0000_0111; done = 1'b1;
    repeat (4) cyc("R6");
    // R3: grant held while done is low even as requests vanish
    req = 8'b0000_0010; cyc("R3");
    done = 1'b0; req = 8'b0000_0000;
    repeat (3) cyc("R3");
    req = 8'b1000_0000; repeat (2) cyc("R3");
    // R8: idle rounds keep the pointer
    done = 1'b1; req = 8'h00;
    repeat (3) cyc("R8");
    // R7: sparse low requests reveal the pointer position
    req = 8'b0000_0101; repeat (3) cyc("R7");
    req = 8'b0000_1001; cyc("R4");
    req = 8'b0000_0101; cyc("R7");
    // R4 / R5: high group dominates, highest number wins
    req = 8'b1001_1001; cyc("R4");
    req = 8'b0110_1000; cyc("R5");
    req = 8'b0001_1111; cyc("R5");
    // R2: random traffic with occasional release
    for (int i = 0; i < 3000; i++) begin
      req  = 8'($urandom);
      done = (($urandom % 3) == 0);
      cyc("R2");
    end
    // R1: reset in mid-traffic
    rst = 1'b1; cyc("R1");
    rst = 1'b0; req = 8'b0000_0110; done = 1'b1; cyc("R1");
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule